// File: doc/BRIEF.md
# Atomic Read-Modify-Write Register Unit

This unit holds one shared data register and carries out one indivisible read-modify-write operation per accepted request. Several requesters drive their own request lines. Each request carries an opcode and up to two operands. A fixed-priority front arbiter accepts at most one request per cycle. The read of the current value and its update happen in that same cycle, so no other request can act in between.

The operations are plain read, plain write, test-and-set, swap, fetch-and-add and compare-and-swap. The response is registered and comes back one cycle after acceptance. It tags the winning requester and carries the value held before the update, or a success flag in the case of compare-and-swap. Software-style locks map directly onto the unit:
- test-and-set or compare-and-swap acquires a lock;
- a plain write of 0 releases it;
- fetch-and-add hands out tickets.

Top module: `atomic_reg_unit`

## Requirements
- R1: After reset the register holds 0 and `rspValid` is low.
- R2: `reqGrant` is one-hot or zero. It grants the lowest-indexed requester whose `reqValid` bit is set, in the same cycle. A requester that is not granted keeps its request and is served in a later cycle.
- R3: `rspValid` rises exactly one cycle after a grant, and `rspId` carries the index of the granted requester. `rspValid` is low in a cycle that follows a cycle without a grant.
- R4: Opcode 0 (read) returns the current value in `rspOld` and leaves the register unchanged.
- R5: Opcode 1 (write) stores operand A. It returns 0 in `rspOld` and 0 in `rspFlag`.
- R6: Opcode 2 (test-and-set) returns the previous value and leaves the register at 1.
- R7: Opcode 3 (swap) returns the previous value and stores operand A.
- R8: Opcode 4 (fetch-and-add) returns the previous value and stores the previous value plus operand A, wrapping modulo 2^DATA_W.
- R9: Opcode 5 (compare-and-swap) compares the register with operand A. On a match it stores operand B and sets `rspFlag` to 1. On a mismatch it leaves the register unchanged and sets `rspFlag` to 0. In both cases `rspOld` is 0.
- R10: Opcodes 6 and 7 behave as a read: the previous value is returned and the register is unchanged.
- R11: Requests accepted in consecutive cycles act in grant order. Each one sees the value left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request pending, one bit per requester |
| reqOp | input | NUM_REQ*3 | Opcode per requester, requester i in bits [3i+2:3i] |
| reqOpA | input | NUM_REQ*DATA_W | Operand A per requester |
| reqOpB | input | NUM_REQ*DATA_W | Operand B per requester (compare-and-swap new value) |
| reqGrant | output | NUM_REQ | Request accepted this cycle |
| rspValid | output | 1 | Response valid |
| rspId | output | max(1,clog2(NUM_REQ)) | Index of the requester the response belongs to |
| rspOld | output | DATA_W | Value before the update (0 for write and compare-and-swap) |
| rspFlag | output | 1 | Compare-and-swap success |

## Verification
`reqGrant` is combinational, so the bench samples it a moment after driving requests on the falling edge, within the same cycle. The register value and the response both move on the next rising edge. The bench therefore reads `rspValid`, `rspId`, `rspOld` and `rspFlag` on the following falling edge, one cycle after acceptance. It observes the register state through a read issued afterwards, whose result arrives one further cycle later. Arbitration scenarios keep losing requests asserted and check the tag of each response in turn, one per cycle.

// File: rtl/atomic_reg_pkg.sv
package atomic_reg_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_READ  = 3'd0;
  localparam logic [OP_W-1:0] OP_WRITE = 3'd1;
  localparam logic [OP_W-1:0] OP_TAS   = 3'd2;
  localparam logic [OP_W-1:0] OP_SWAP  = 3'd3;
  localparam logic [OP_W-1:0] OP_FADD  = 3'd4;
  localparam logic [OP_W-1:0] OP_CAS   = 3'd5;

  typedef enum logic [1:0] {
    SRC_ONE = 2'd0,
    SRC_OPA = 2'd1,
    SRC_SUM = 2'd2,
    SRC_OPB = 2'd3
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    fire;     // an operation is accepted this cycle
    logic    load;     // update the register
    srcSel_e src;      // next-value source
    logic    hideOld;  // return 0 instead of the old value
    logic    flag;     // compare-and-swap success
  } ctrlStrobe_t;

endpackage

// File: rtl/atomic_reg_arbiter.sv
module atomic_reg_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] reqValid,
  output logic [NUM_REQ-1:0] grant,
  output logic [ID_W-1:0]    grantId,
  output logic               anyGrant
);

  always_comb begin
    grant    = '0;
    grantId  = '0;
    anyGrant = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqValid[i] && !anyGrant) begin
        grant[i] = 1'b1;
        grantId  = ID_W'(i);
        anyGrant = 1'b1;
      end
    end
  end

endmodule

// File: rtl/atomic_reg_ctrl.sv
module atomic_reg_ctrl
  import atomic_reg_pkg::*;
(
  input  logic            fire,
  input  logic [OP_W-1:0] op,
  input  logic            cmpEq,
  output ctrlStrobe_t     strobe
);

  always_comb begin
    strobe         = '0;
    strobe.fire    = fire;
    strobe.src     = SRC_OPA;
    unique case (op)
      OP_WRITE: begin
        strobe.load    = fire;
        strobe.hideOld = 1'b1;
      end
      OP_TAS: begin
        strobe.load = fire;
        strobe.src  = SRC_ONE;
      end
      OP_SWAP: strobe.load = fire;
      OP_FADD: begin
        strobe.load = fire;
        strobe.src  = SRC_SUM;
      end
      OP_CAS: begin
        strobe.load    = fire & cmpEq;
        strobe.src     = SRC_OPB;
        strobe.hideOld = 1'b1;
        strobe.flag    = cmpEq;
      end
      default: ;  // read and unassigned codes: no update
    endcase
  end

endmodule

// File: rtl/atomic_reg_datapath.sv
module atomic_reg_datapath
  import atomic_reg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ID_W-1:0]   grantId,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] curValue,
  output logic              cmpEq,
  output logic              rspValid,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspOld,
  output logic              rspFlag
);

  logic [DATA_W-1:0] nextValue;

  assign cmpEq = (curValue == opA);

  always_comb begin
    unique case (strobe.src)
      SRC_ONE: nextValue = DATA_W'(1);
      SRC_OPA: nextValue = opA;
      SRC_SUM: nextValue = curValue + opA;
      default: nextValue = opB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curValue <= '0;
      rspValid <= 1'b0;
      rspId    <= '0;
      rspOld   <= '0;
      rspFlag  <= 1'b0;
    end else begin
      if (strobe.load) curValue <= nextValue;
      rspValid <= strobe.fire;
      if (strobe.fire) begin
        rspId   <= grantId;
        rspOld  <= strobe.hideOld ? '0 : curValue;
        rspFlag <= strobe.flag;
      end
    end
  end

endmodule

// File: rtl/atomic_reg_unit.sv
module atomic_reg_unit
  import atomic_reg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_REQ = 4,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REQ-1:0]        reqValid,
  input  logic [NUM_REQ*OP_W-1:0]   reqOp,
  input  logic [NUM_REQ*DATA_W-1:0] reqOpA,
  input  logic [NUM_REQ*DATA_W-1:0] reqOpB,
  output logic [NUM_REQ-1:0]        reqGrant,
  output logic                      rspValid,
  output logic [ID_W-1:0]           rspId,
  output logic [DATA_W-1:0]         rspOld,
  output logic                      rspFlag
);

  logic [ID_W-1:0]   grantId;
  logic              anyGrant;
  logic [OP_W-1:0]   selOp;
  logic [DATA_W-1:0] selA;
  logic [DATA_W-1:0] selB;
  logic [DATA_W-1:0] curValue;
  logic              cmpEq;
  ctrlStrobe_t       strobe;

  atomic_reg_arbiter #(.NUM_REQ(NUM_REQ)) uArb (
    .reqValid(reqValid),
    .grant(reqGrant),
    .grantId(grantId),
    .anyGrant(anyGrant)
  );

  assign selOp = reqOp[grantId*OP_W +: OP_W];
  assign selA  = reqOpA[grantId*DATA_W +: DATA_W];
  assign selB  = reqOpB[grantId*DATA_W +: DATA_W];

  atomic_reg_ctrl uCtrl (
    .fire(anyGrant),
    .op(selOp),
    .cmpEq(cmpEq),
    .strobe(strobe)
  );

  atomic_reg_datapath #(.DATA_W(DATA_W), .ID_W(ID_W)) uDp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .grantId(grantId),
    .opA(selA),
    .opB(selB),
    .curValue(curValue),
    .cmpEq(cmpEq),
    .rspValid(rspValid),
    .rspId(rspId),
    .rspOld(rspOld),
    .rspFlag(rspFlag)
  );

endmodule

// File: rtl/atomic_reg_checker.sv
module atomic_reg_checker
  import atomic_reg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_REQ = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_REQ-1:0] reqValid,
  input logic [NUM_REQ-1:0] reqGrant,
  input logic              rspValid,
  input logic              rspFlag,
  input logic [DATA_W-1:0] rspOld,
  input logic [DATA_W-1:0] curValue,
  input logic [OP_W-1:0]   selOp,
  input logic [DATA_W-1:0] selA,
  input logic [DATA_W-1:0] selB
);

  logic anyReq;
  assign anyReq = |reqValid;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant));

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  assert_grant_when_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> (reqGrant != '0));

  assert_rsp_follows_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant != '0) |=> rspValid);

  assert_no_rsp_without_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant == '0) |=> !rspValid);

  assert_read_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && selOp == OP_READ) |=> $stable(curValue));

  assert_tas_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && selOp == OP_TAS) |=> (curValue == DATA_W'(1)) && rspOld == $past(curValue));

  assert_fadd_sum_R8: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && selOp == OP_FADD) |=> curValue == DATA_W'($past(curValue) + $past(selA)));

  assert_cas_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && selOp == OP_CAS && curValue == selA) |=> rspFlag && curValue == $past(selB) && rspOld == '0);

  assert_cas_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && selOp == OP_CAS && curValue != selA) |=> !rspFlag && $stable(curValue));

endmodule

bind atomic_reg_unit atomic_reg_checker #(.DATA_W(DATA_W), .NUM_REQ(NUM_REQ)) uChk (
  .clk(clk),
  .rstN(rstN),
  .reqValid(reqValid),
  .reqGrant(reqGrant),
  .rspValid(rspValid),
  .rspFlag(rspFlag),
  .rspOld(rspOld),
  .curValue(curValue),
  .selOp(selOp),
  .selA(selA),
  .selB(selB)
);

// File: tb/tb_atomic_reg_unit.sv
module tb_atomic_reg_unit;

  localparam int DATA_W  = 16;
  localparam int NUM_REQ = 4;
  localparam int OP_W    = 3;
  localparam int ID_W    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_REQ-1:0]        reqValid = '0;
  logic [NUM_REQ*OP_W-1:0]   reqOp = '0;
  logic [NUM_REQ*DATA_W-1:0] reqOpA = '0;
  logic [NUM_REQ*DATA_W-1:0] reqOpB = '0;
  logic [NUM_REQ-1:0]        reqGrant;
  logic                      rspValid;
  logic [ID_W-1:0]           rspId;
  logic [DATA_W-1:0]         rspOld;
  logic                      rspFlag;

  int totalCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;  // 250 MHz

  atomic_reg_unit #(.DATA_W(DATA_W), .NUM_REQ(NUM_REQ)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqOpA(reqOpA), .reqOpB(reqOpB), .reqGrant(reqGrant),
    .rspValid(rspValid), .rspId(rspId), .rspOld(rspOld), .rspFlag(rspFlag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setReq(input int idx, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    reqValid[idx] = 1'b1;
    reqOp[idx*OP_W +: OP_W]      = op;
    reqOpA[idx*DATA_W +: DATA_W] = a;
    reqOpB[idx*DATA_W +: DATA_W] = b;
  endtask

  // Issue one operation alone; response sampled one cycle after acceptance (R3)
  task automatic doOp(input int idx, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                      output logic [15:0] old, output logic flg);
    @(negedge clk);
    setReq(idx, op, a, b);
    @(negedge clk);
    reqValid[idx] = 1'b0;
    check(rspValid && rspId == ID_W'(idx), "R3 rsp tag", {rspValid, 14'd0, rspId}, {1'b1, 14'd0, ID_W'(idx)});
    old = rspOld;
    flg = rspFlag;
  endtask

  task automatic readVal(output logic [15:0] v);
    logic f;
    doOp(0, 3'd0, 16'd0, 16'd0, v, f);
  endtask

  task automatic testReset();
    logic [15:0] v;
    check(!rspValid, "R1 rspValid after reset", rspValid, 0);
    readVal(v);
    check(v == 16'd0, "R1 reset value", v, 0);
  endtask

  task automatic testReadWrite();
    logic [15:0] v; logic f;
    doOp(1, 3'd1, 16'h1234, 16'h0, v, f);
    check(v == 16'd0 && !f, "R5 write returns 0", {f, v}, 0);
    readVal(v);
    check(v == 16'h1234, "R5 write stored", v, 16'h1234);
    doOp(2, 3'd0, 16'hFFFF, 16'hFFFF, v, f);
    check(v == 16'h1234, "R4 read returns value", v, 16'h1234);
    readVal(v);
    check(v == 16'h1234, "R4 read unchanged", v, 16'h1234);
  endtask

  task automatic testTasSwap();
    logic [15:0] v; logic f;
    doOp(0, 3'd1, 16'h0, 16'h0, v, f);
    doOp(3, 3'd2, 16'h0, 16'h0, v, f);
    check(v == 16'd0, "R6 tas old free", v, 0);
    doOp(2, 3'd2, 16'h0, 16'h0, v, f);
    check(v == 16'd1, "R6 tas old held", v, 1);
    readVal(v);
    check(v == 16'd1, "R6 tas leaves 1", v, 1);
    doOp(1, 3'd3, 16'hBEEF, 16'h0, v, f);
    check(v == 16'd1, "R7 swap old", v, 1);
    readVal(v);
    check(v == 16'hBEEF, "R7 swap stored", v, 16'hBEEF);
  endtask

  task automatic testFetchAdd();
    logic [15:0] v; logic f;
    doOp(0, 3'd1, 16'd10, 16'h0, v, f);
    doOp(1, 3'd4, 16'd5, 16'h0, v, f);
    check(v == 16'd10, "R8 fadd old", v, 10);
    doOp(2, 3'd4, 16'd1, 16'h0, v, f);
    check(v == 16'd15, "R8 fadd second", v, 15);
    doOp(0, 3'd1, 16'hFFFF, 16'h0, v, f);
    doOp(3, 3'd4, 16'd2, 16'h0, v, f);
    check(v == 16'hFFFF, "R8 fadd wrap old", v, 16'hFFFF);
    readVal(v);
    check(v == 16'd1, "R8 fadd wraps", v, 1);
  endtask

  task automatic testCas();
    logic [15:0] v; logic f;
    doOp(0, 3'd1, 16'd0, 16'h0, v, f);
    doOp(1, 3'd5, 16'd0, 16'd7, v, f);
    check(f && v == 16'd0, "R9 cas hit", {f, v}, {1'b1, 16'd0});
    readVal(v);
    check(v == 16'd7, "R9 cas stored", v, 7);
    doOp(2, 3'd5, 16'd0, 16'd9, v, f);
    check(!f && v == 16'd0, "R9 cas miss", {f, v}, 0);
    readVal(v);
    check(v == 16'd7, "R9 cas miss unchanged", v, 7);
  endtask

  task automatic testUnknownOp();
    logic [15:0] v; logic f;
    doOp(0, 3'd6, 16'h5555, 16'h5555, v, f);
    check(v == 16'd7, "R10 op6 returns old", v, 7);
    doOp(1, 3'd7, 16'h5555, 16'h5555, v, f);
    check(v == 16'd7, "R10 op7 returns old", v, 7);
    readVal(v);
    check(v == 16'd7, "R10 unchanged", v, 7);
  endtask

  // R2/R11: contention, one acceptance per cycle, lowest index first
  task automatic testArbitration();
    logic [15:0] v;
    doOp(0, 3'd1, 16'd100, 16'h0, v, v[0]);
    @(negedge clk);
    setReq(3, 3'd4, 16'd1, 16'h0);
    setReq(1, 3'd4, 16'd10, 16'h0);
    #1;
    check(reqGrant == 4'b0010, "R2 lowest index wins", reqGrant, 4'b0010);
    @(negedge clk);
    reqValid[1] = 1'b0;
    check(rspValid && rspId == 2'd1 && rspOld == 16'd100, "R11 first served", {rspId, rspOld}, {2'd1, 16'd100});
    #1;
    check(reqGrant == 4'b1000, "R2 held request granted", reqGrant, 4'b1000);
    @(negedge clk);
    reqValid[3] = 1'b0;
    check(rspValid && rspId == 2'd3 && rspOld == 16'd110, "R11 second sees first", {rspId, rspOld}, {2'd3, 16'd110});
    @(negedge clk);
    check(!rspValid, "R3 no response when idle", rspValid, 0);
    readVal(v);
    check(v == 16'd111, "R11 final value", v, 111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadWrite();
    testTasSwap();
    testFetchAdd();
    testCas();
    testUnknownOp();
    testArbitration();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule